// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

This block supervises software with a 10-bit down counter fed by a two-stage prescaler: a coarse stage that passes every cycle or one cycle in 256, followed by a fine stage that divides by a power of two from 1 to 128. Software programs a reload value, a window limit and a warning level through a small register interface. To keep the block quiet it must "kick" the counter, and only inside the window. The window is open when the count has fallen to the window limit or below. A kick made too early is treated as a fault, and so is a count that runs past zero.

Each kind of fault has its own sticky status bit. A control bit decides whether a fault drives the reset-request pin or the fault-interrupt pin. A third sticky bit records that the count reached the warning level, which gives software a chance to kick before the counter underflows. All pins are plain control and status levels. The block has no streamed data, so it has no valid/ready handshake.

Top module: `wwd_top`

## Requirements
- R1: Register map (write with `wr_en`, read combinationally on `rd_data`):
  - 0 = control: bit0 run, bit1 fault-to-reset, bits[4:2] fine divider exponent, bit5 coarse divide-by-256.
  - 1 = window limit, 2 = warning level, 3 = reload value.
  - 4 = kick (write only, data ignored).
  - 5 = status: bit0 underflow, bit1 early kick, bit2 warning. Writing 1 to a bit clears it.
  - 6 = current count (read only).
  - After reset, control and status read 0, the reload value and window limit read 1023, the count reads 1023, and all three output pins are low.
- R2: While run is 0, the count follows the reload value, both prescaler stages are held cleared, and kicks neither change the count nor set any status bit.
- R3: While running, the count drops by exactly one on each prescaler tick and holds between ticks. With both stages at divide-by-1 it drops every cycle, and the first decrement lands on the first clock edge after the edge that set run.
- R4: The tick period is (bit5 ? 256 : 1) × 2^(bits[4:2]) cycles. After run rises or a legal kick, the first tick lands on the edge that completes one full period.
- R5: A kick while the count is at or below the window limit loads the reload value and restarts both prescaler stages.
- R6: A kick while the count is above the window limit sets status bit1 and leaves the count running as if no kick had occurred.
- R7: A tick while the count is 0 reloads the reload value and sets status bit1's neighbour, status bit0 (underflow).
- R8: A legal kick on the same edge as an underflow tick wins: the count reloads and status bit0 stays clear.
- R9: Status bit2 sets on the clock edge at which the running count equals the warning level. `irq_warn` is a copy of status bit2.
- R10: With fault-to-reset set, `rst_req` is high whenever status bit0 or bit1 is set. With it clear, `irq_fault` is high instead. The two pins are never high together.
- R11: Writing the status register clears exactly the bits written as 1. Bits written as 0 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| rst_req | output | 1 | Fault routed as reset request |
| irq_fault | output | 1 | Fault routed as interrupt |
| irq_warn | output | 1 | Warning interrupt |

## Verification
The bench builds the block with its default parameters:
- a 10-bit counter,
- a 256 coarse stage,
- a seven-step fine stage.

These defaults put the slowest setting, 32768 cycles per tick, within a short run, so the bench times the first tick exactly at divide-by-4, at divide-by-256 and at the combined maximum. Fault and warning checks run at divide-by-1 with small reload values. This lets the bench place kicks on the exact cycle: one above the window, one inside it, and one on the edge where underflow would otherwise fire. It also catches the warning flag on the precise edge where the count equals the warning level.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_WINDOW = 3'd1,
    A_WARN   = 3'd2,
    A_RELOAD = 3'd3,
    A_KICK   = 3'd4,
    A_STATUS = 3'd5,
    A_COUNT  = 3'd6
  } wwd_addr_e;

  // control bit positions that do not depend on parameters
  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_FRST  = 1;
  localparam int unsigned CTL_FSEL  = 2;

  // status bit positions
  localparam int unsigned ST_UF    = 0;
  localparam int unsigned ST_EARLY = 1;
  localparam int unsigned ST_WARN  = 2;

  typedef struct packed {
    logic warn;
    logic early;
    logic uf;
  } wwd_evt_t;

endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale #(
  parameter int unsigned COARSE_DIV = 256,
  parameter int unsigned FINE_LOG   = 7,
  parameter int unsigned SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             coarse_sel,
  input  logic [SEL_W-1:0] fine_sel,
  output logic             tick
);

  logic coarse_tick;

  // coarse stage: pass-through, or one pulse per COARSE_DIV cycles
  generate
    if (COARSE_DIV > 1) begin : g_coarse
      localparam int unsigned CW = $clog2(COARSE_DIV);
      logic [CW-1:0] ccnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ccnt <= '0;
        end else if (!run || restart || !coarse_sel) begin
          ccnt <= '0;
        end else if (ccnt == CW'(COARSE_DIV - 1)) begin
          ccnt <= '0;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end

      assign coarse_tick = coarse_sel ? (ccnt == CW'(COARSE_DIV - 1)) : 1'b1;
    end else begin : g_nocoarse
      logic unused_coarse_sel;
      assign unused_coarse_sel = coarse_sel;
      assign coarse_tick = 1'b1;
    end
  endgenerate

  // fine stage: binary counter, tick when the selected low bits are all ones
  logic [FINE_LOG-1:0] fcnt;
  logic [FINE_LOG-1:0] fmask;

  always_comb begin
    for (int i = 0; i < FINE_LOG; i++) begin
      fmask[i] = (i < int'(fine_sel));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
    end else if (!run || restart) begin
      fcnt <= '0;
    end else if (coarse_tick) begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign tick = run && coarse_tick && ((fcnt & fmask) == fmask);

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] window_val,
  input  logic [CNT_W-1:0] warn_val,
  output logic [CNT_W-1:0] count,
  output logic             restart,
  output wwd_evt_t         evt
);

  logic in_window;
  logic legal_kick;
  logic at_zero;

  assign in_window  = (count <= window_val);
  assign legal_kick = run && kick && in_window;
  assign at_zero    = (count == '0);
  assign restart    = legal_kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
    end else if (!run) begin
      count <= reload_val;
    end else if (legal_kick) begin
      count <= reload_val;
    end else if (tick) begin
      count <= at_zero ? reload_val : count - 1'b1;
    end
  end

  always_comb begin
    evt.uf    = run && tick && at_zero && !legal_kick;
    evt.early = run && kick && !in_window;
    evt.warn  = run && (count == warn_val);
  end

endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  count,
  input  wwd_evt_t          evt,
  output logic              run,
  output logic              fault_rst,
  output logic [SEL_W-1:0]  fine_sel,
  output logic              coarse_sel,
  output logic [CNT_W-1:0]  window_val,
  output logic [CNT_W-1:0]  warn_val,
  output logic [CNT_W-1:0]  reload_val,
  output logic              kick,
  output logic [2:0]        flags
);

  localparam int unsigned CTL_CRS = CTL_FSEL + SEL_W;
  localparam int unsigned CTL_W   = CTL_CRS + 1;

  logic [CTL_W-1:0] ctrl_q;
  logic             wr_ctrl, wr_win, wr_warn, wr_rel, wr_stat;
  logic [2:0]       set_v, clr_v;
  logic             unused_wr_hi;

  // upper data bits above the counter width carry no register field
  assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_win  = wr_en && (wr_addr == A_WINDOW);
  assign wr_warn = wr_en && (wr_addr == A_WARN);
  assign wr_rel  = wr_en && (wr_addr == A_RELOAD);
  assign wr_stat = wr_en && (wr_addr == A_STATUS);
  assign kick    = wr_en && (wr_addr == A_KICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      window_val <= '1;
      warn_val   <= '0;
      reload_val <= '1;
    end else begin
      if (wr_ctrl) ctrl_q     <= wr_data[CTL_W-1:0];
      if (wr_win)  window_val <= wr_data[CNT_W-1:0];
      if (wr_warn) warn_val   <= wr_data[CNT_W-1:0];
      if (wr_rel)  reload_val <= wr_data[CNT_W-1:0];
    end
  end

  assign run        = ctrl_q[CTL_RUN];
  assign fault_rst  = ctrl_q[CTL_FRST];
  assign fine_sel   = ctrl_q[CTL_FSEL +: SEL_W];
  assign coarse_sel = ctrl_q[CTL_CRS];

  // sticky status, write-one-to-clear; a new event outranks a clear
  always_comb begin
    set_v          = '0;
    set_v[ST_UF]   = evt.uf;
    set_v[ST_EARLY]= evt.early;
    set_v[ST_WARN] = evt.warn;
    clr_v          = wr_stat ? wr_data[2:0] : 3'b000;
  end

  generate
    for (genvar b = 0; b < 3; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags[b] <= 1'b0;
        end else if (set_v[b]) begin
          flags[b] <= 1'b1;
        end else if (clr_v[b]) begin
          flags[b] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:   rd_data = DATA_W'(ctrl_q);
      A_WINDOW: rd_data = DATA_W'(window_val);
      A_WARN:   rd_data = DATA_W'(warn_val);
      A_RELOAD: rd_data = DATA_W'(reload_val);
      A_STATUS: rd_data = DATA_W'(flags);
      A_COUNT:  rd_data = DATA_W'(count);
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned COARSE_DIV = 256,
  parameter int unsigned FINE_LOG   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic              irq_fault,
  output logic              irq_warn
);

  localparam int unsigned SEL_W = $clog2(FINE_LOG + 1);

  logic             run, fault_rst, coarse_sel, kick, tick, restart;
  logic [SEL_W-1:0] fine_sel;
  logic [CNT_W-1:0] window_val, warn_val, reload_val, count;
  logic [2:0]       flags;
  wwd_evt_t         evt;
  logic             fault_any;

  wwd_regs #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .count     (count),
    .evt       (evt),
    .run       (run),
    .fault_rst (fault_rst),
    .fine_sel  (fine_sel),
    .coarse_sel(coarse_sel),
    .window_val(window_val),
    .warn_val  (warn_val),
    .reload_val(reload_val),
    .kick      (kick),
    .flags     (flags)
  );

  wwd_prescale #(
    .COARSE_DIV(COARSE_DIV),
    .FINE_LOG  (FINE_LOG),
    .SEL_W     (SEL_W)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (restart),
    .coarse_sel(coarse_sel),
    .fine_sel  (fine_sel),
    .tick      (tick)
  );

  wwd_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .kick      (kick),
    .reload_val(reload_val),
    .window_val(window_val),
    .warn_val  (warn_val),
    .count     (count),
    .restart   (restart),
    .evt       (evt)
  );

  assign fault_any = flags[ST_UF] | flags[ST_EARLY];
  assign rst_req   = fault_any & fault_rst;
  assign irq_fault = fault_any & ~fault_rst;
  assign irq_warn  = flags[ST_WARN];

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             kick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] window_val,
  input logic [CNT_W-1:0] warn_val,
  input logic [CNT_W-1:0] reload_val,
  input logic [2:0]       flags,
  input logic             rst_req,
  input logic             irq_fault
);

  AST_IDLE_FOLLOWS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == $past(reload_val)); // R2

  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !kick && count != '0) |=> count == $past(count) - CNT_W'(1)); // R3

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !kick) |=> $stable(count)); // R3

  AST_LEGAL_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick && count <= window_val) |=> count == $past(reload_val)); // R5

  AST_EARLY_KICK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick && count > window_val) |=> flags[1]); // R6

  AST_UNDERFLOW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !kick && count == '0) |=> (flags[0] && count == $past(reload_val))); // R7

  AST_WARN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count == warn_val) |=> flags[2]); // R9

  AST_FAULT_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_fault)); // R10

endmodule

bind wwd_top wwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .tick      (tick),
  .kick      (kick),
  .count     (count),
  .window_val(window_val),
  .warn_val  (warn_val),
  .reload_val(reload_val),
  .flags     (flags),
  .rst_req   (rst_req),
  .irq_fault (irq_fault)
);

// File: tb/sim_wwd_top.sv
`timescale 1ns/1ps
module sim_wwd_top;

  localparam int unsigned PINS = 7;   // pseudo address: output pins

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rst_req, irq_fault, irq_warn;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int          q_addr[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];
  event        pushed;

  always #10 clk = ~clk;

  wwd_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .irq_fault(irq_fault), .irq_warn(irq_warn)
  );

  // monitor: pops each expected item and compares against the design
  initial begin
    forever begin
      @(pushed);
      #1;
      while (q_addr.size() > 0) begin
        int a;
        logic [15:0] e, got;
        string t;
        a = q_addr.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        got = (a == PINS) ? {13'b0, rst_req, irq_fault, irq_warn} : rd_data;
        n_tests++;
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", t, a, got, e);
        end
      end
    end
  end

  // driver side: expectation push, register write, wait
  task automatic expect_rd(input int a, input logic [15:0] e, input string t);
    if (a != PINS) rd_addr = 3'(a);
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(t);
    -> pushed;
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(6, 16'h03FF, "R1 count");
    expect_rd(5, 16'h0000, "R1 status");
    expect_rd(1, 16'h03FF, "R1 window");
    expect_rd(PINS, 16'h0000, "R1 pins");

    wr(3'd3, 16'd20);
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0001);
    expect_rd(6, 16'd20, "R2 loaded on start");
    step(3);
    expect_rd(6, 16'd17, "R3 decrement per cycle");

    // R6 early kick
    wr(3'd4, 16'h0000);
    expect_rd(5, 16'h0002, "R6 early flag");
    expect_rd(6, 16'd16, "R6 no reload");
    expect_rd(PINS, 16'h0002, "R10 interrupt mode");
    wr(3'd5, 16'h0002);
    expect_rd(5, 16'h0000, "R11 clear");
    expect_rd(PINS, 16'h0000, "R11 pins low");

    // R5 legal kick
    step(6);
    expect_rd(6, 16'd9, "R3 count");
    wr(3'd4, 16'h0000);
    expect_rd(6, 16'd20, "R5 reload");
    expect_rd(5, 16'h0000, "R5 no fault");

    // R9 warning edge
    step(15);
    expect_rd(6, 16'd5, "R9 count at level");
    expect_rd(5, 16'h0000, "R9 not yet");
    step(1);
    expect_rd(5, 16'h0004, "R9 warn flag");
    expect_rd(PINS, 16'h0001, "R9 irq_warn");
    wr(3'd5, 16'h0004);
    expect_rd(5, 16'h0000, "R11 warn cleared");

    // R7 underflow
    step(3);
    expect_rd(6, 16'd0, "R7 at zero");
    expect_rd(5, 16'h0000, "R7 not yet");
    step(1);
    expect_rd(6, 16'd20, "R7 reload");
    expect_rd(5, 16'h0001, "R7 flag");
    expect_rd(PINS, 16'h0002, "R10 fault irq");
    wr(3'd0, 16'h0003);
    expect_rd(PINS, 16'h0004, "R10 reset mode");
    wr(3'd5, 16'h0001);
    expect_rd(PINS, 16'h0000, "R11 uf cleared");

    // R8 kick at zero beats underflow
    step(18);
    expect_rd(6, 16'd0, "R8 at zero");
    expect_rd(5, 16'h0004, "R8 warn passed");
    wr(3'd4, 16'h0000);
    expect_rd(6, 16'd20, "R8 reload");
    expect_rd(5, 16'h0004, "R8 no uf");
    expect_rd(PINS, 16'h0001, "R8 pins");
    wr(3'd5, 16'h0004);
    expect_rd(5, 16'h0000, "R11 cleared again");

    // R4 fine divide by 4
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0009);
    expect_rd(6, 16'd20, "R4 fine start");
    step(3);
    expect_rd(6, 16'd20, "R4 fine hold");
    step(1);
    expect_rd(6, 16'd19, "R4 fine first tick");
    step(8);
    expect_rd(6, 16'd17, "R4 fine rate");

    // R4 coarse divide by 256
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0021);
    step(255);
    expect_rd(6, 16'd20, "R4 coarse hold");
    step(1);
    expect_rd(6, 16'd19, "R4 coarse tick");

    // R4 combined maximum
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h003D);
    step(32767);
    expect_rd(6, 16'd20, "R4 max hold");
    step(1);
    expect_rd(6, 16'd19, "R4 max tick");

    // R2 kick ignored while stopped
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    expect_rd(5, 16'h0000, "R2 kick ignored");
    expect_rd(6, 16'd20, "R2 follows reload");

    #5;
    done = 1'b1;
    finish_run();
  end

endmodule